// File: doc/BRIEF.md
# Transit Fare Gate Controller

This block runs one fare transaction at a transit gate. It sits idle until a card is presented. It then takes a snapshot of the card's remaining balance and trip count and waits for a fare request from the reader. When the request arrives, it checks that both counters are non-zero. It then either opens the gate for one cycle or refuses entry with a reason code. On a successful fare it hands back the debited balance and trip count, to be written to the card.

If the reader link drops, or no fare request comes within a bounded window, the controller enters a fault state. That state holds until reset or until the link comes back. A card left on the reader after a completed transaction is not charged again: the card must be lifted before the next read can start. A state register that holds an unused code is recovered to idle, and this is flagged on the error output.

Top module: `fare_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low, the controller is idle and `access_o`, `error_o`, `deny_code_o`, `balance_o` and `quota_o` are all zero.
- R2: In idle with the re-arm flag set, a cycle with `card_present_i` high moves the controller to the read state at the next edge. With `card_present_i` low it stays idle.
- R3: On entry to the read state, `balance_i` and `trip_quota_i` are captured and shown on `balance_o` / `quota_o`. Later changes on those inputs have no effect on validation or on the outputs until the next capture.
- R4: In the read state, `link_ok_i` low sends the controller to the fault state. Otherwise `request_fare_i` high sends it to validation. With neither, after `READ_TIMEOUT` (16) consecutive read cycles it enters the fault state, so `error_o` first rises 17 edges after the capturing edge's preceding cycle of card detection.
- R5: Validation takes one cycle. It goes to grant only if both captured counters are greater than zero, and to deny otherwise.
- R6: Grant lasts exactly one cycle with `access_o` = 1. During that cycle `balance_o` and `quota_o` each show the captured value minus 1. The next state is idle.
- R7: Deny lasts exactly one cycle with `access_o` = 0. `deny_code_o` bit 0 is set when the captured trip count is zero, and bit 1 is set when the captured balance is zero. The values are 01, 10 or 11, and 00 outside deny. The next state is idle.
- R8: In the fault state, `error_o` = 1 and `access_o` = 0. The controller leaves for idle only on reset, or on a cycle where `link_ok_i` is 1 after being 0 in the previous cycle.
- R9: After a grant or a deny, the controller does not capture again until `card_present_i` has been seen low while idle.
- R10: The states use the 3-bit codes idle 000, read 001, validate 010, grant 011, deny 100, fault 101. A state register holding 110 or 111 raises `error_o` for that cycle and returns to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_present_i | input | 1 | Card detected on the reader |
| request_fare_i | input | 1 | Reader asks for the fare to be taken |
| link_ok_i | input | 1 | Reader connectivity is good |
| balance_i | input | 8 | Balance read from the card |
| trip_quota_i | input | 8 | Trips remaining on the card |
| access_o | output | 1 | Gate open pulse |
| deny_code_o | output | 2 | Refusal reason, valid during deny |
| error_o | output | 1 | Fault state or illegal state code |
| balance_o | output | 8 | Captured or debited balance for write-back |
| quota_o | output | 8 | Captured or debited trip count for write-back |

## Verification
The properties assume that every input is settled and known at each rising edge. They also assume that the state register is only disturbed by upsets that produce the two unused codes, never the six legal ones. The bench drives all inputs on the falling edge. It keeps the link mostly high with occasional drops, so that both fault entry and recovery occur. It injects one unused state code by briefly overriding the state register between edges. The random phase mixes zero and non-zero counters so that every refusal code and the grant path are reached.

// File: rtl/fare_gate_pkg.sv
package fare_gate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_READ  = 3'b001,
    ST_CHECK = 3'b010,
    ST_GRANT = 3'b011,
    ST_DENY  = 3'b100,
    ST_FAULT = 3'b101
  } fg_state_e;

  localparam int unsigned DENY_W = 2;
endpackage

// File: rtl/fare_gate_timer.sv
module fare_gate_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/fare_gate_ledger.sv
module fare_gate_ledger
  import fare_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              debit_i,
  input  logic [DATA_W-1:0] balance_i,
  input  logic [DATA_W-1:0] quota_i,
  output logic [DATA_W-1:0] balance_o,
  output logic [DATA_W-1:0] quota_o,
  output logic              funds_ok_o,
  output logic [DENY_W-1:0] reason_o
);
  logic [DATA_W-1:0] bal_q, trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bal_q  <= '0;
      trip_q <= '0;
    end else if (capture_i) begin
      bal_q  <= balance_i;
      trip_q <= quota_i;
    end else if (debit_i) begin
      bal_q  <= bal_q - 1'b1;
      trip_q <= trip_q - 1'b1;
    end
  end

  // bit0: trips exhausted, bit1: balance exhausted
  assign reason_o   = {bal_q == '0, trip_q == '0};
  assign funds_ok_o = (reason_o == '0);
  assign balance_o  = bal_q;
  assign quota_o    = trip_q;
endmodule

// File: rtl/fare_gate_fsm.sv
module fare_gate_fsm
  import fare_gate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      card_present_i,
  input  logic      request_fare_i,
  input  logic      link_ok_i,
  input  logic      timeout_i,
  input  logic      funds_ok_i,
  output fg_state_e state_o,
  output logic      capture_o,
  output logic      debit_o,
  output logic      illegal_o
);
  fg_state_e state_q, state_d;
  logic      armed_q, link_prev_q;

  always_comb begin
    state_d   = state_q;
    illegal_o = 1'b0;
    case (state_q)
      ST_IDLE:  if (card_present_i && armed_q) state_d = ST_READ;
      ST_READ: begin
        if (!link_ok_i)          state_d = ST_FAULT;
        else if (request_fare_i) state_d = ST_CHECK;
        else if (timeout_i)      state_d = ST_FAULT;
      end
      ST_CHECK: state_d = funds_ok_i ? ST_GRANT : ST_DENY;
      ST_GRANT: state_d = ST_IDLE;
      ST_DENY:  state_d = ST_IDLE;
      ST_FAULT: if (link_ok_i && !link_prev_q) state_d = ST_IDLE;
      default: begin
        state_d   = ST_IDLE;
        illegal_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      armed_q     <= 1'b1;
      link_prev_q <= 1'b1;
    end else begin
      state_q     <= state_d;
      link_prev_q <= link_ok_i;
      // a card left on the reader must be lifted before the next read
      if (state_q == ST_GRANT || state_q == ST_DENY) armed_q <= 1'b0;
      else if (state_q == ST_IDLE && !card_present_i) armed_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && card_present_i && armed_q;
  assign debit_o   = (state_q == ST_CHECK) && funds_ok_i;
endmodule

// File: rtl/fare_gate_ctrl.sv
module fare_gate_ctrl
  import fare_gate_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned READ_TIMEOUT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_present_i,
  input  logic              request_fare_i,
  input  logic              link_ok_i,
  input  logic [DATA_W-1:0] balance_i,
  input  logic [DATA_W-1:0] trip_quota_i,
  output logic              access_o,
  output logic [DENY_W-1:0] deny_code_o,
  output logic              error_o,
  output logic [DATA_W-1:0] balance_o,
  output logic [DATA_W-1:0] quota_o
);
  fg_state_e         state;
  logic              capture, debit, illegal, expired, funds_ok;
  logic [DENY_W-1:0] reason;

  fare_gate_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .card_present_i (card_present_i),
    .request_fare_i (request_fare_i),
    .link_ok_i      (link_ok_i),
    .timeout_i      (expired),
    .funds_ok_i     (funds_ok),
    .state_o        (state),
    .capture_o      (capture),
    .debit_o        (debit),
    .illegal_o      (illegal)
  );

  fare_gate_timer #(.TIMEOUT(READ_TIMEOUT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state == ST_READ),
    .expired_o (expired)
  );

  fare_gate_ledger #(.DATA_W(DATA_W)) u_ledger (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .debit_i    (debit),
    .balance_i  (balance_i),
    .quota_i    (trip_quota_i),
    .balance_o  (balance_o),
    .quota_o    (quota_o),
    .funds_ok_o (funds_ok),
    .reason_o   (reason)
  );

  assign access_o    = (state == ST_GRANT);
  assign deny_code_o = (state == ST_DENY) ? reason : '0;
  assign error_o     = (state == ST_FAULT) || illegal;
endmodule

// File: rtl/fare_gate_chk.sv
module fare_gate_chk #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned READ_TIMEOUT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        state_i,
  input logic              card_present_i,
  input logic              link_ok_i,
  input logic              access_o,
  input logic [1:0]        deny_code_o,
  input logic              error_o,
  input logic [DATA_W-1:0] balance_o,
  input logic [DATA_W-1:0] quota_o
);
  localparam logic [2:0] S_IDLE = 3'b000, S_READ = 3'b001, S_CHECK = 3'b010,
                         S_GRANT = 3'b011, S_DENY = 3'b100, S_FAULT = 3'b101;

  int unsigned rd_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_run <= 0;
    else if (state_i == S_READ) rd_run <= rd_run + 1;
    else                        rd_run <= 0;
  end

  p_read_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_READ && $past(state_i) != S_READ) |-> $past(card_present_i));

  p_hold_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_CHECK) |-> ($stable(balance_o) && $stable(quota_o)));

  p_link_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_READ && !link_ok_i) |=> (state_i == S_FAULT));

  p_read_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_READ) |-> (rd_run < READ_TIMEOUT));

  p_funds_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_CHECK && balance_o != '0 && quota_o != '0) |=> (state_i == S_GRANT));

  p_debit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_GRANT) |-> (access_o && balance_o == $past(balance_o) - 1'b1
                              && quota_o == $past(quota_o) - 1'b1));

  p_grant_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_GRANT) |=> (state_i == S_IDLE && !access_o));

  p_deny_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DENY) |-> (deny_code_o != 2'b00 && !access_o));

  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FAULT && !(link_ok_i && !$past(link_ok_i))) |=> (state_i == S_FAULT));

  p_fault_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FAULT) |-> (error_o && !access_o));

  p_illegal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i[2:1] == 2'b11) |-> error_o ##1 (state_i == S_IDLE));
endmodule

bind fare_gate_ctrl fare_gate_chk #(.DATA_W(DATA_W), .READ_TIMEOUT(READ_TIMEOUT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_i        (state),
  .card_present_i (card_present_i),
  .link_ok_i      (link_ok_i),
  .access_o       (access_o),
  .deny_code_o    (deny_code_o),
  .error_o        (error_o),
  .balance_o      (balance_o),
  .quota_o        (quota_o)
);

// File: tb/tb_fare_gate_ctrl.sv
`timescale 1ns/1ps
module tb_fare_gate_ctrl;
  import fare_gate_pkg::*;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       card = 0, req = 0, link = 1;
  logic [7:0] bal_in = 0, trip_in = 0;
  logic       access_o, error_o;
  logic [1:0] deny_code_o;
  logic [7:0] balance_o, quota_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fare_gate_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .card_present_i(card), .request_fare_i(req),
    .link_ok_i(link), .balance_i(bal_in), .trip_quota_i(trip_in),
    .access_o(access_o), .deny_code_o(deny_code_o), .error_o(error_o),
    .balance_o(balance_o), .quota_o(quota_o));

  // behavioural reference: 0 idle,1 read,2 check,3 grant,4 deny,5 fault,6/7 illegal
  int m_st = 0, m_bal = 0, m_trip = 0, m_cnt = 0;
  bit m_armed = 1, m_lprev = 1;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_bal = 0; m_trip = 0; m_cnt = 0; m_armed = 1; m_lprev = 1;
    end else begin
      case (m_st)
        0: if (card && m_armed) begin
             m_st = 1; m_bal = bal_in; m_trip = trip_in; m_cnt = 0;
           end else if (!card) m_armed = 1;
        1: if (!link) m_st = 5;
           else if (req) m_st = 2;
           else if (m_cnt == 15) m_st = 5;
           else m_cnt++;
        2: if (m_bal > 0 && m_trip > 0) begin
             m_st = 3; m_bal--; m_trip--;
           end else m_st = 4;
        3, 4: begin m_st = 0; m_armed = 0; end
        5: if (link && !m_lprev) m_st = 0;
        default: m_st = 0;
      endcase
      m_lprev = link;
    end
  end

  task automatic chk(string req_tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req_tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison; outputs depend on registers only
  always @(negedge clk) if (rst_ni && !done) begin
    chk("R6 access", int'(access_o), int'(m_st == 3));
    chk("R7 deny_code", int'(deny_code_o),
        (m_st == 4) ? ((int'(m_bal == 0) << 1) | int'(m_trip == 0)) : 0);
    chk("R8 error", int'(error_o), int'(m_st >= 5));
    chk("R3 balance", int'(balance_o), m_bal);
    chk("R3 quota", int'(quota_o), m_trip);
  end

  task automatic drive(bit c, bit r, bit l, int b, int t);
    @(negedge clk);
    card = c; req = r; link = l; bal_in = 8'(b); trip_in = 8'(t);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // card on, one read cycle, then fare request, card off
  task automatic fare(int b, int t);
    drive(1, 0, 1, b, t);
    drive(1, 1, 1, 99, 99);
    drive(0, 0, 1, 77, 77);
    idle(3);
  endtask

  int cyc;
  bit seen;

  initial begin
    #50000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    // R1: outputs during reset
    chk("R1 access", int'(access_o), 0);
    chk("R1 error", int'(error_o), 0);
    chk("R1 deny", int'(deny_code_o), 0);
    chk("R1 balance", int'(balance_o), 0);
    chk("R1 quota", int'(quota_o), 0);
    @(negedge clk); rst_ni = 1;

    // R2: no card, inputs wiggle, nothing captured
    drive(0, 1, 1, 40, 40); idle(4);
    chk("R2 idle no capture", int'(balance_o), 0);

    // R5 R6: grant with 1/1 lands on 0/0
    drive(1, 0, 1, 1, 1);
    drive(1, 1, 1, 9, 9);   // R3: changed inputs mid-transaction
    drive(0, 0, 1, 9, 9);   // now in check
    @(negedge clk);         // grant
    chk("R6 grant access", int'(access_o), 1);
    chk("R6 balance debit", int'(balance_o), 0);
    chk("R6 quota debit", int'(quota_o), 0);
    idle(3);

    // R7: each refusal code
    fare(5, 0); fare(0, 5); fare(0, 0);
    drive(1, 0, 1, 0, 3); drive(1, 1, 1, 0, 3); drive(0, 0, 1, 0, 3);
    @(negedge clk);
    chk("R7 code no balance", int'(deny_code_o), 2);
    idle(3);

    // R4: timeout, error first seen 17 edges after card driven
    drive(1, 0, 1, 4, 4);
    cyc = 0; seen = 0;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk); cyc++;
      if (error_o) seen = 1;
    end
    chk("R4 timeout latency", cyc, 17);
    // R8: sticky while link steady high
    drive(0, 0, 1, 4, 4); idle(5);
    chk("R8 fault sticky", int'(error_o), 1);
    drive(0, 0, 0, 4, 4); drive(0, 0, 1, 4, 4); // restore: low then high
    @(negedge clk);
    chk("R8 fault exit", int'(error_o), 0);

    // R4: link drop in read
    drive(1, 0, 1, 2, 2); drive(1, 1, 0, 2, 2);
    @(negedge clk);
    chk("R4 link drop", int'(error_o), 1);
    drive(0, 0, 1, 2, 2); idle(2);

    // R9: card held after grant, no second charge
    drive(1, 0, 1, 3, 3); drive(1, 1, 1, 3, 3); drive(1, 0, 1, 50, 50);
    idle(8);
    chk("R9 no recharge bal", int'(balance_o), 2);
    chk("R9 no recharge trip", int'(quota_o), 2);
    drive(0, 0, 1, 50, 50); drive(1, 0, 1, 50, 50); @(negedge clk);
    chk("R9 rearmed capture", int'(balance_o), 50);
    drive(0, 0, 1, 0, 0); idle(20);
    drive(0, 0, 0, 0, 0); drive(0, 0, 1, 0, 0); idle(3);

    // R10: inject unused code 110 between edges
    @(negedge clk);
    #1 force dut.u_fsm.state_q = fg_state_e'(3'b110);
    #1 release dut.u_fsm.state_q;
    m_st = 6;
    #0.2 chk("R10 illegal flag", int'(error_o), 1);
    @(negedge clk);
    chk("R10 recovered", int'(error_o), 0);

    // random traffic
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 24) != 0,
            $urandom % 4, $urandom % 4);
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule